// File: doc/BRIEF.md
# Parallel-Lane Coarse Delay Line

This block delays a wideband sample stream by a whole number of samples that software sets at run time. Every clock carries one word of eight 10-bit samples, so a delay is split in two. The word part is served from an on-chip circular memory. The remainder, from 0 to 7, is served by a barrel shift that combines the word read at the word offset with the word before it. The output word has one cycle of latency. Its timestamp is recomputed on the output side: it is the input word's timestamp minus the delay being applied.

Software writes a delay, a signed delay rate and a target timestamp into staging registers, and the last of those writes arms them. The armed set loads on the first valid word whose timestamp matches the target at word granularity. From then on, two matched interpolators advance the delay by the rate once per valid word. One supplies the memory word offset and the other the lane shift. The delay saturates at zero and at the largest delay the memory can hold. A programmed delay above that limit is clamped and sets a sticky flag.

There is one instance per polarization, each with its own register set. Output valid stays low until enough words have been stored to serve the delay in force. A sync marker on the input restarts that priming count.

Top module: `coarse_delay_line`

## Requirements
- R1: After reset, out_valid and clamp_flag are 0. Until the first armed load, the delay is 0 samples and the rate is 0.
- R2: For an input valid word i with applied delay D, the output word appears one clock later. Its lane j, with lane 0 the oldest sample in bits [9:0] and lane 7 in bits [79:70], equals input sample number 8i+j−D of the stream. This holds for any D, including values that are not a multiple of 8.
- R3: The output timestamp equals the input word's timestamp minus D, modulo 2^48.
- R4: Registers are written with cfg_we. At cfg_addr 0 the write sets the delay in samples (unsigned). At 1 it sets the rate (32-bit two's complement, 16 fractional bits, in samples per word). At 2 it sets target timestamp bits [31:0]. At 3 it sets target bits [47:32] from cfg_wdata[15:0] and arms delay, rate and target together.
- R5: An armed set takes effect on the first valid word whose in_ts[47:3] equals target[47:3]; earlier words keep the old delay. The load word itself uses the new delay exactly.
- R6: Arming again before a load replaces the pending set. The old target then causes no change.
- R7: After each valid word, the internal delay accumulator adds the rate. The applied delay is the floor of the accumulator.
- R8: The accumulator saturates at 0 and at MAXD = 8·DEPTH−8 samples (504 for DEPTH 64).
- R9: Arming a delay above MAXD loads MAXD instead and sets clamp_flag, which stays 1 until reset.
- R10: out_valid is 1 only for a valid input word where the count of valid words since reset or sync, not counting this word, is at least floor(D/8)+1. That count saturates at DEPTH.
- R11: A valid word with in_sync=1 restarts the count: this word sees a count of 0.
- R12: A clock with in_valid=0 gives out_valid=0 on the next clock. out_data and out_ts keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sync | input | 1 | Start-of-block marker, restarts priming |
| in_ts | input | 48 | Sample timestamp of lane 0 of the input word |
| in_data | input | 80 | Eight 10-bit samples, lane 0 lowest |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| out_valid | output | 1 | Output word valid |
| out_ts | output | 48 | Regenerated output timestamp |
| out_data | output | 80 | Delayed samples, lane 0 lowest |
| clamp_flag | output | 1 | Sticky flag for a clamped delay |

## Verification
The bench targets these corner cases:
- The word where a load lands, with a target whose low three bits are non-zero. A design that compared all timestamp bits would never load; one that loaded a word late would show the old delay on the load word.
- A re-arm before the first target arrives. A queuing design would jump twice.
- Shifts that are not multiples of eight, and a timestamp that wraps past 2^48. A wrong lane join or a wrong read offset would give stale or misordered samples.
- A half-sample rate, a negative rate that drives the delay to zero, and a positive rate running into the clamped maximum. These expose flooring, wrap-around and missing saturation.
- Priming after a sync at a small delay and at the maximum delay. A design that failed to restart the count would emit stale memory contents as valid.
- Idle cycles. A design that dropped valid late, or let the data move while idle, would be caught.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic [1:0] {
    REG_DELAY  = 2'd0,
    REG_RATE   = 2'd1,
    REG_TS_LO  = 2'd2,
    REG_TS_ARM = 2'd3
  } cd_reg_e;

  localparam int RATE_W    = 32;
  localparam int RATE_FRAC = 16;
endpackage

// File: rtl/cd_interp.sv
module cd_interp #(
  parameter int IW   = 9,
  parameter int FRAC = 16,
  parameter int RW   = 32,
  parameter int LB   = 3,
  parameter int MAXD = 504,
  parameter int SEL  = 0,
  parameter int PW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [IW-1:0] load_delay,
  input  logic [RW-1:0] load_rate,
  output logic [PW-1:0] part
);
  localparam int AW   = IW + FRAC;
  localparam int SUMW = AW + RW + 1;
  localparam logic [AW-1:0] ACC_MAX = AW'(MAXD) << FRAC;
  localparam logic [IW-1:0] LMASK   = IW'((1 << LB) - 1);

  logic [AW-1:0]          acc_q, acc_d, base;
  logic [RW-1:0]          rate_q, rate_d, rate_use;
  logic signed [SUMW-1:0] sum;
  logic [IW-1:0]          d_int;

  always_comb begin
    base     = load ? {load_delay, {FRAC{1'b0}}} : acc_q;
    rate_use = load ? load_rate : rate_q;
    sum      = $signed({{(SUMW-AW){1'b0}}, base})
             + $signed({{(SUMW-RW){rate_use[RW-1]}}, rate_use});
    acc_d    = acc_q;
    rate_d   = rate_q;
    if (adv) begin
      rate_d = rate_use;
      if (sum < 0)
        acc_d = '0;
      else if (sum > $signed({{(SUMW-AW){1'b0}}, ACC_MAX}))
        acc_d = ACC_MAX;
      else
        acc_d = sum[AW-1:0];
    end
    d_int = base[AW-1:FRAC];
    part  = PW'((SEL == 0) ? (d_int >> LB) : (d_int & LMASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      rate_q <= '0;
    end else begin
      acc_q  <= acc_d;
      rate_q <= rate_d;
    end
  end

  AST_ACC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= ACC_MAX); // R8
endmodule

// File: rtl/cd_barrel.sv
module cd_barrel #(
  parameter int LANES = 8,
  parameter int SW    = 10,
  parameter int LB    = 3
) (
  input  logic [LANES*SW-1:0] cur,
  input  logic [LANES*SW-1:0] prev,
  input  logic [LB-1:0]       shift,
  output logic [LANES*SW-1:0] dout
);
  logic [2*LANES*SW-1:0] joined;
  assign joined = {cur, prev};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign dout[j*SW +: SW] = joined[(j + LANES - int'(shift))*SW +: SW];
  end
endmodule

// File: rtl/coarse_delay_line.sv
module coarse_delay_line
  import cd_pkg::*;
#(
  parameter int LANES = 8,
  parameter int SW    = 10,
  parameter int DEPTH = 64,
  parameter int TSW   = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_sync,
  input  logic [TSW-1:0]      in_ts,
  input  logic [LANES*SW-1:0] in_data,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic                out_valid,
  output logic [TSW-1:0]      out_ts,
  output logic [LANES*SW-1:0] out_data,
  output logic                clamp_flag
);
  localparam int LB   = $clog2(LANES);
  localparam int AWD  = $clog2(DEPTH);
  localparam int IW   = AWD + LB;
  localparam int MAXD = DEPTH * LANES - LANES;
  localparam int WD   = LANES * SW;
  localparam logic [AWD:0] FILL_MAX = (AWD+1)'(DEPTH);

  // staging and armed registers
  logic [31:0]     stg_delay_q, stg_delay_d, stg_rate_q, stg_rate_d, stg_lo_q, stg_lo_d;
  logic            arm_q, arm_d;
  logic [IW-1:0]   arm_delay_q, arm_delay_d;
  logic [31:0]     arm_rate_q, arm_rate_d;
  logic [TSW-1:0]  arm_ts_q, arm_ts_d;
  logic            clamp_q, clamp_d;
  logic            arm_wr, over, load_now;

  // stream state
  logic [AWD-1:0]  wp_q, wp_d, rd_cur, rd_prev;
  logic [AWD:0]    fill_q, fill_d, fill_eff;
  logic            prime_ok;
  logic [WD-1:0]   mem [DEPTH];
  logic [WD-1:0]   cur_word, prev_word, shifted;
  logic [AWD-1:0]  wd;
  logic [LB-1:0]   sh;
  logic            ov_q, ov_d;
  logic [TSW-1:0]  ots_q, ots_d;
  logic [WD-1:0]   odat_q, odat_d;

  cd_interp #(.IW(IW), .FRAC(RATE_FRAC), .RW(RATE_W), .LB(LB), .MAXD(MAXD),
              .SEL(0), .PW(AWD)) u_word_interp (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .load(load_now),
    .load_delay(arm_delay_q), .load_rate(arm_rate_q), .part(wd));

  cd_interp #(.IW(IW), .FRAC(RATE_FRAC), .RW(RATE_W), .LB(LB), .MAXD(MAXD),
              .SEL(1), .PW(LB)) u_lane_interp (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .load(load_now),
    .load_delay(arm_delay_q), .load_rate(arm_rate_q), .part(sh));

  cd_barrel #(.LANES(LANES), .SW(SW), .LB(LB)) u_barrel (
    .cur(cur_word), .prev(prev_word), .shift(sh), .dout(shifted));

  // register interface and timed load
  always_comb begin
    arm_wr      = cfg_we && (cfg_addr == REG_TS_ARM);
    over        = stg_delay_q > 32'(MAXD);
    load_now    = arm_q && in_valid && (in_ts[TSW-1:LB] == arm_ts_q[TSW-1:LB]);
    stg_delay_d = (cfg_we && cfg_addr == REG_DELAY) ? cfg_wdata : stg_delay_q;
    stg_rate_d  = (cfg_we && cfg_addr == REG_RATE)  ? cfg_wdata : stg_rate_q;
    stg_lo_d    = (cfg_we && cfg_addr == REG_TS_LO) ? cfg_wdata : stg_lo_q;
    arm_d       = arm_wr ? 1'b1 : (load_now ? 1'b0 : arm_q);
    arm_delay_d = arm_delay_q;
    arm_rate_d  = arm_rate_q;
    arm_ts_d    = arm_ts_q;
    clamp_d     = clamp_q;
    if (arm_wr) begin
      arm_delay_d = over ? IW'(MAXD) : stg_delay_q[IW-1:0];
      arm_rate_d  = stg_rate_q;
      arm_ts_d    = {cfg_wdata[TSW-33:0], stg_lo_q};
      clamp_d     = clamp_q | over;
    end
  end

  // memory read, priming and output stage
  always_comb begin
    rd_cur    = wp_q - wd;
    rd_prev   = wp_q - wd - {{(AWD-1){1'b0}}, 1'b1};
    cur_word  = (wd == '0) ? in_data : mem[rd_cur];
    prev_word = mem[rd_prev];
    fill_eff  = in_sync ? '0 : fill_q;
    prime_ok  = fill_eff >= ({1'b0, wd} + {{AWD{1'b0}}, 1'b1});
    wp_d      = wp_q;
    fill_d    = fill_q;
    ots_d     = ots_q;
    odat_d    = odat_q;
    ov_d      = in_valid && prime_ok;
    if (in_valid) begin
      wp_d   = wp_q + {{(AWD-1){1'b0}}, 1'b1};
      fill_d = (fill_eff == FILL_MAX) ? FILL_MAX : fill_eff + {{AWD{1'b0}}, 1'b1};
      ots_d  = in_ts - {{(TSW-IW){1'b0}}, wd, sh};
      odat_d = shifted;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) mem[wp_q] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_delay_q <= '0;
      stg_rate_q  <= '0;
      stg_lo_q    <= '0;
      arm_q       <= 1'b0;
      arm_delay_q <= '0;
      arm_rate_q  <= '0;
      arm_ts_q    <= '0;
      clamp_q     <= 1'b0;
      wp_q        <= '0;
      fill_q      <= '0;
      ov_q        <= 1'b0;
      ots_q       <= '0;
      odat_q      <= '0;
    end else begin
      stg_delay_q <= stg_delay_d;
      stg_rate_q  <= stg_rate_d;
      stg_lo_q    <= stg_lo_d;
      arm_q       <= arm_d;
      arm_delay_q <= arm_delay_d;
      arm_rate_q  <= arm_rate_d;
      arm_ts_q    <= arm_ts_d;
      clamp_q     <= clamp_d;
      wp_q        <= wp_d;
      fill_q      <= fill_d;
      ov_q        <= ov_d;
      ots_q       <= ots_d;
      odat_q      <= odat_d;
    end
  end

  assign out_valid  = ov_q;
  assign out_ts     = ots_q;
  assign out_data   = odat_q;
  assign clamp_flag = clamp_q;

  AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ({wd, sh} <= IW'(MAXD))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_ts))); // R12
  AST_LOAD_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_now && !arm_wr) |=> !arm_q); // R5
  AST_CLAMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_flag |=> clamp_flag); // R9
endmodule

// File: tb/coarse_delay_line_bench.sv
module coarse_delay_line_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int MAXD  = DEPTH * 8 - 8;
  localparam logic [47:0] TS0 = 48'hFFFF_FFFF_FE00;

  logic        clk, rst_n;
  logic        in_valid, in_sync, cfg_we;
  logic [47:0] in_ts;
  logic [79:0] in_data;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        out_valid, clamp_flag;
  logic [47:0] out_ts;
  logic [79:0] out_data;

  coarse_delay_line u_coarse_delay_line (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .in_ts(in_ts), .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_ts(out_ts),
    .out_data(out_data), .clamp_flag(clamp_flag));

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model state
  int          widx = 0;
  longint      m_acc = 0, m_rate = 0;
  bit          m_armed = 0, m_clamp = 0;
  longint      m_arm_d = 0, m_arm_r = 0;
  logic [47:0] m_arm_ts = '0;
  logic [31:0] stg_d = 0, stg_r = 0, stg_lo = 0;
  int          m_fill = 0;
  bit          pend = 0, pv = 0;
  logic [79:0] pdata;
  logic [47:0] pts;
  string       ptag;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [9:0] samp(input int n);
    return 10'((n * 97 + 13) & 10'h3FF);
  endfunction

  function automatic logic [79:0] mkword(input int i);
    logic [79:0] w;
    for (int j = 0; j < 8; j++) w[j*10 +: 10] = samp(8*i + j);
    return w;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit s, input bit we, input logic [1:0] a,
                     input logic [31:0] d, input string tag);
    bit ld;
    longint base, nxt, rt;
    int dl, w;
    logic [47:0] ts;
    @(negedge clk);
    if (pend) begin
      chk(out_valid === pv, {ptag, " R10 valid"}, 80'(out_valid), 80'(pv));
      if (pv) begin
        chk(out_data === pdata, {ptag, " R2 data"}, out_data, pdata);
        chk(out_ts === pts, {ptag, " R3 ts"}, 80'(out_ts), 80'(pts));
      end
    end
    ts = TS0 + 48'(8 * widx);
    in_valid = v; in_sync = s; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    in_ts = ts; in_data = mkword(widx);
    pv = 0; ptag = tag; pend = 1;
    if (v) begin
      ld   = m_armed && (ts[47:3] == m_arm_ts[47:3]);
      base = ld ? (m_arm_d <<< 16) : m_acc;
      rt   = ld ? m_arm_r : m_rate;
      dl   = int'(base >>> 16);
      w    = dl / 8;
      if (s) m_fill = 0;
      pv    = (m_fill >= w + 1);
      pdata = '0;
      for (int j = 0; j < 8; j++) pdata[j*10 +: 10] = samp(8*widx + j - dl);
      pts   = ts - 48'(dl);
      m_fill = (m_fill >= DEPTH) ? DEPTH : m_fill + 1;
      m_rate = rt;
      nxt = base + rt;
      if (nxt < 0) nxt = 0;
      if (nxt > (longint'(MAXD) <<< 16)) nxt = longint'(MAXD) <<< 16;
      m_acc = nxt;
      if (ld) m_armed = 0;
      widx++;
    end
    if (we) begin
      case (a)
        2'd0: stg_d = d;
        2'd1: stg_r = d;
        2'd2: stg_lo = d;
        default: begin
          m_armed  = 1;
          m_arm_d  = (stg_d > MAXD) ? MAXD : longint'(stg_d);
          if (stg_d > MAXD) m_clamp = 1;
          m_arm_r  = longint'(signed'(stg_r));
          m_arm_ts = {d[15:0], stg_lo};
        end
      endcase
    end
  endtask

  task automatic words(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1, 0, 0, 2'd0, 0, tag);
  endtask

  // arm delay/rate for the word `ahead` words from now, target low bits = lo3
  task automatic arm(input logic [31:0] dly, input logic [31:0] rate, input int ahead,
                     input int lo3, input string tag);
    logic [47:0] t;
    t = TS0 + 48'(8 * (widx + ahead)) + 48'(lo3);
    cyc(0, 0, 1, 2'd0, dly, tag);
    cyc(0, 0, 1, 2'd1, rate, tag);
    cyc(0, 0, 1, 2'd2, t[31:0], tag);
    cyc(0, 0, 1, 2'd3, {16'h0, t[47:32]}, tag);
  endtask

  task automatic t_reset;
    chk(out_valid === 1'b0, "R1 reset valid", 80'(out_valid), 0);
    chk(clamp_flag === 1'b0, "R1 reset clamp", 80'(clamp_flag), 0);
  endtask

  task automatic t_zero;       words(10, "R1 zero-delay");                      endtask
  task automatic t_load;       arm(13, 0, 4, 5, "R4"); words(8, "R5 load"); words(8, "R2 shift5"); endtask
  task automatic t_rearm;      arm(100, 0, 3, 0, "R6"); arm(21, 0, 8, 2, "R6"); words(14, "R6 replace"); endtask
  task automatic t_prime;      cyc(1, 1, 0, 2'd0, 0, "R10 prime"); words(6, "R10 prime"); endtask
  task automatic t_rate;       arm(40, 32'h0000_8000, 2, 0, "R7"); words(20, "R7 rate"); endtask
  task automatic t_floor;      arm(3, 32'hFFFF_0000, 1, 0, "R8"); words(10, "R8 floor"); endtask

  task automatic t_clamp;
    arm(10000, 32'h0001_0000, 1, 0, "R9");
    words(6, "R8 ceiling");
    chk(clamp_flag === 1'b1, "R9 clamp flag", 80'(clamp_flag), 1);
  endtask

  task automatic t_sync;
    cyc(1, 1, 0, 2'd0, 0, "R11 sync");
    words(70, "R11 sync");
  endtask

  task automatic t_idle;
    logic [79:0] sd;
    logic [47:0] st;
    words(2, "R12 idle");
    cyc(0, 0, 0, 2'd0, 0, "R12 idle");
    sd = out_data; st = out_ts;
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 2'd0, 0, "R12 idle");
    @(negedge clk);
    chk(out_valid === 1'b0, "R12 idle valid", 80'(out_valid), 0);
    chk(out_data === sd, "R12 idle data hold", out_data, sd);
    chk(out_ts === st, "R12 idle ts hold", 80'(out_ts), 80'(st));
    chk(clamp_flag === m_clamp, "R9 clamp still set", 80'(clamp_flag), 80'(m_clamp));
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_sync = 0; cfg_we = 0; cfg_addr = 0;
    cfg_wdata = 0; in_ts = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_load();
    t_rearm();
    t_prime();
    t_rate();
    t_floor();
    t_clamp();
    t_sync();
    t_idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule